// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block collects single-cycle event pulses from a serial storage link into an 11-bit register of sticky pending bits. Software clears pending bits with an active-low write: a zero in a bit position of the write data clears that bit, and a one leaves it as it is. A handler can therefore acknowledge exactly the events it has read by writing the bitwise complement of the value it read, limited to the 11 valid bits. Writing zero to the whole register clears every pending event at start-up.

A companion 11-bit register selects which pending bits may raise the interrupt. In that register a set bit blocks its source. The four low positions have fixed roles: bit 0 is the ATA command completion, bit 1 is the critical error, bit 2 is the error, and bit 3 is the serial link error. Pending bits are captured whether or not they are blocked. A registered OR of the unblocked pending bits forms the raw interrupt. The raw interrupt leaves the block only while the top-level enable flag is set. Software loads that flag from bit 11 of its write data.

Top module: `irq_stat_mask`

## Requirements
- R1: After reset the pending register reads 0, the block register reads 0x7FF (all sources blocked), the enable flag is 0, and both interrupt outputs are 0.
- R2: An event pulse on input bit i makes pending bit i read 1 after the next clock edge. The bit stays at 1 through later idle cycles until software clears it.
- R3: A pending-register write clears each bit whose write-data bit is 0. Each bit whose write-data bit is 1 keeps its value, so writing 0x7FF changes nothing.
- R4: Writing 0 to the pending register clears every pending bit.
- R5: If an event on bit i arrives in the same cycle as a write that clears bit i, the event wins and bit i reads 1 afterwards.
- R6: Events are captured in the pending register even while their source is blocked.
- R7: A block-register write loads write-data bits 10:0. Bit 0 blocks the ATA command source, bit 1 the critical error, bit 2 the error, and bit 3 the serial error. A set bit keeps that pending bit from affecting the interrupt.
- R8: The raw interrupt is a register. After each clock edge it equals the OR of (pending AND NOT blocked) as that value stood before the edge.
- R9: The enable flag loads write-data bit 11 on an enable write. The gated interrupt equals raw interrupt AND enable flag, and it follows an enable write at the same edge.
- R10: Writing (NOT pending) AND 0x7FF, using the value read earlier, clears only the bits that were pending then. An event that arrives later stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | NSRC (11) | Single-cycle event pulses, one per source |
| stat_we | input | 1 | Write strobe for the pending register (zero clears) |
| mask_we | input | 1 | Write strobe for the block register |
| ena_we | input | 1 | Write strobe for the enable flag |
| wdata | input | WDW (12) | Write data shared by the three write strobes |
| status_o | output | NSRC (11) | Pending register contents |
| mask_o | output | NSRC (11) | Block register contents |
| enable_o | output | 1 | Enable flag |
| irq_raw_o | output | 1 | Registered OR of the unblocked pending bits |
| irq_o | output | 1 | Raw interrupt gated by the enable flag |

## Verification
Pending bits, the block register and the enable flag change one edge after the cycle in which their event or write is driven. The raw interrupt lags the pending and block registers by one more edge, because it is registered from their values before that edge. The gated output is combinational from the raw interrupt and the enable flag, so it follows both of them in the same cycle. The driver steps a reference model once per cycle. It queues the state expected after the coming edge, and the monitor compares that state one time unit after the edge. In this way a blocked event, for example, can be checked first for its capture and only then for the quiet interrupt line.

// File: rtl/ism_pkg.sv
package ism_pkg;

  // Next pending value: apply an active-low clear write, then let new events win.
  function automatic logic [31:0] ism_next_pending(input logic [31:0] cur,
                                                   input logic        wr,
                                                   input logic [31:0] wd,
                                                   input logic [31:0] ev);
    logic [31:0] kept;
    kept = wr ? (cur & wd) : cur;
    return kept | ev;
  endfunction

  // Unblocked pending sources: a set block bit suppresses its source.
  function automatic logic [31:0] ism_unblocked(input logic [31:0] pend,
                                                input logic [31:0] blk);
    return pend & ~blk;
  endfunction

endpackage

// File: rtl/ism_status_bank.sv
module ism_status_bank #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] event_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] stat_o
);
  import ism_pkg::*;

  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] stat_d;
  logic [31:0]     nxt_w;

  assign nxt_w  = ism_next_pending(32'(stat_q), wr_i, 32'(wdata_i), 32'(event_i));
  assign stat_d = nxt_w[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R2
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_i) |=> ((stat_q & $past(event_i)) == $past(event_i)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(event_i)) == '0);

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i == '0 && event_i == '0) |=> (stat_q == '0));

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (event_i & ~wdata_i) != '0) |=> ((stat_q & $past(event_i)) == $past(event_i)));

endmodule

// File: rtl/ism_mask_reg.sv
module ism_mask_reg #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] mask_o
);
  localparam logic [NSRC-1:0] BLOCK_ALL = '1;

  logic [NSRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= BLOCK_ALL;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(wdata_i)));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));

endmodule

// File: rtl/ism_irq_reduce.sv
module ism_irq_reduce #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] stat_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            irq_o
);
  import ism_pkg::*;

  logic [31:0] live_w;
  logic        any_live;
  logic        irq_q;

  assign live_w   = ism_unblocked(32'(stat_i), 32'(mask_i));
  assign any_live = |live_w[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_live;
  end

  assign irq_o = irq_q;

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_i & ~mask_i) == '0) |=> !irq_q);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_i & ~mask_i) != '0) |=> irq_q);

endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask #(
  parameter int NSRC = 11,
  parameter int WDW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] event_i,
  input  logic            stat_we,
  input  logic            mask_we,
  input  logic            ena_we,
  input  logic [WDW-1:0]  wdata,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            enable_o,
  output logic            irq_raw_o,
  output logic            irq_o
);
  localparam int ENA_BIT = WDW - 1;

  logic [NSRC-1:0] stat_w;
  logic [NSRC-1:0] mask_w;
  logic            raw_w;
  logic            ena_q;

  ism_status_bank #(.NSRC(NSRC)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (event_i),
    .wr_i    (stat_we),
    .wdata_i (wdata[NSRC-1:0]),
    .stat_o  (stat_w)
  );

  ism_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_we),
    .wdata_i (wdata[NSRC-1:0]),
    .mask_o  (mask_w)
  );

  ism_irq_reduce #(.NSRC(NSRC)) u_red (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_w),
    .mask_i (mask_w),
    .irq_o  (raw_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      ena_q <= 1'b0;
    else if (ena_we) ena_q <= wdata[ENA_BIT];
  end

  assign status_o  = stat_w;
  assign mask_o    = mask_w;
  assign enable_o  = ena_q;
  assign irq_raw_o = raw_w;
  assign irq_o     = raw_w & ena_q;

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (enable_o && irq_raw_o));

  // R9
  ena_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ena_we |=> (enable_o == $past(wdata[ENA_BIT])));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0 && mask_o == '1 && !enable_o && !irq_raw_o));

endmodule

// File: tb/irq_stat_mask_test.sv
module irq_stat_mask_test;
  localparam int NSRC = 11;
  localparam int WDW  = 12;

  typedef struct {
    logic [NSRC-1:0] stat;
    logic [NSRC-1:0] mask;
    logic            ena;
    logic            raw;
    logic            irq;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] event_i = '0;
  logic            stat_we = 1'b0, mask_we = 1'b0, ena_we = 1'b0;
  logic [WDW-1:0]  wdata = '0;
  logic [NSRC-1:0] status_o, mask_o;
  logic            enable_o, irq_raw_o, irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  exp_t q[$];
  exp_t got;

  // reference model state
  logic [NSRC-1:0] m_stat = '0;
  logic [NSRC-1:0] m_mask = '1;
  logic            m_ena  = 1'b0;
  logic            m_raw  = 1'b0;

  always #5 clk = ~clk;

  irq_stat_mask #(.NSRC(NSRC), .WDW(WDW)) uut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i),
    .stat_we(stat_we), .mask_we(mask_we), .ena_we(ena_we), .wdata(wdata),
    .status_o(status_o), .mask_o(mask_o), .enable_o(enable_o),
    .irq_raw_o(irq_raw_o), .irq_o(irq_o)
  );

  task automatic compare(input exp_t e);
    vectors++;
    if (status_o !== e.stat || mask_o !== e.mask || enable_o !== e.ena ||
        irq_raw_o !== e.raw || irq_o !== e.irq) begin
      errors++;
      $display("FAIL %s: got stat=%h mask=%h ena=%b raw=%b irq=%b exp stat=%h mask=%h ena=%b raw=%b irq=%b",
               e.tag, status_o, mask_o, enable_o, irq_raw_o, irq_o,
               e.stat, e.mask, e.ena, e.raw, e.irq);
    end
  endtask

  // monitor: one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      got = q.pop_front();
      compare(got);
    end
  end

  // driver: set inputs at a falling edge, advance the model, queue the expectation
  task automatic step(input logic [NSRC-1:0] ev, input logic sw, input logic mw,
                      input logic ew, input logic [WDW-1:0] wd, input string tag);
    exp_t e;
    logic [NSRC-1:0] kept;
    event_i = ev; stat_we = sw; mask_we = mw; ena_we = ew; wdata = wd;
    kept  = sw ? (m_stat & wd[NSRC-1:0]) : m_stat;
    m_raw = |(m_stat & ~m_mask);
    m_stat = kept | ev;
    if (mw) m_mask = wd[NSRC-1:0];
    if (ew) m_ena = wd[WDW-1];
    e.stat = m_stat; e.mask = m_mask; e.ena = m_ena;
    e.raw = m_raw; e.irq = m_raw & m_ena; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.stat = '0; r.mask = '1; r.ena = 1'b0; r.raw = 1'b0; r.irq = 1'b0; r.tag = "R1";
    compare(r);
    rst_n = 1'b1;
    compare(r);

    step(11'h001, 1'b0, 1'b0, 1'b0, '0, "R2 ata event");
    idle("R2 sticky");
    idle("R2 sticky again");
    step(11'h008, 1'b0, 1'b0, 1'b0, '0, "R6 serial error captured while blocked");
    idle("R7 all blocked keeps raw low");
    // unblock ATA (bit0) and serial error (bit3)
    step('0, 1'b0, 1'b1, 1'b0, 12'h7F6, "R7 unblock bits 0 and 3");
    idle("R8 raw rises one edge after unblock");
    step('0, 1'b0, 1'b0, 1'b1, 12'h800, "R9 enable set");
    idle("R9 gated irq");
    step(11'h020, 1'b0, 1'b0, 1'b0, '0, "R6 bit5 event while blocked");
    // acknowledge what was pending earlier (0x009)
    step('0, 1'b1, 1'b0, 1'b0, 12'h7F6, "R10 ack serviced bits only");
    idle("R8 raw falls after ack");
    step('0, 1'b1, 1'b0, 1'b0, 12'h7FF, "R3 ones keep bits");
    step('0, 1'b1, 1'b0, 1'b0, 12'h7DF, "R3 zero clears bit5");
    step(11'h004, 1'b1, 1'b0, 1'b0, 12'h7FB, "R5 event beats clear");
    step(11'h002, 1'b0, 1'b1, 1'b0, 12'h7FD, "R7 unblock critical error");
    idle("R8 raw from critical error");
    step('0, 1'b0, 1'b0, 1'b1, 12'h000, "R9 enable cleared gates irq");
    idle("R9 raw high irq low");
    step('0, 1'b0, 1'b1, 1'b1, 12'hFFF, "R7 block all, R9 enable");
    idle("R7 all blocked drops raw");
    step(11'h400, 1'b0, 1'b0, 1'b0, '0, "R6 high bit captured blocked");
    step('0, 1'b1, 1'b0, 1'b0, 12'h000, "R4 zero write clears all");
    idle("R4 stays clear");
    idle("R8 quiet");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule